// File: doc/BRIEF.md
# Host Shared-Memory Bus Arbiter Interface

This block is a clocked slave port that lets an asynchronous host processor reach a 16-bit shared RAM and a 32-entry register file. An internal protocol engine uses the same RAM through a request/grant pair. The engine always wins a tie. When both host select and host strobe are seen low on a rising clock edge and the engine is neither requesting nor holding the RAM, the block pulls its active-low transfer enable low. That edge starts a host transfer.

During the transfer, the block freezes the host address on the first rising edge after the transfer starts. It freezes the target select and the read/write line on the first falling edge after the transfer starts. It then counts a fixed number of wait clocks that depends on the target, and pulls its active-low ready low. Read data and the data-bus enable are valid from the edge where ready falls. They stay valid until the host raises the strobe, and the edge that sees the raised strobe returns the port to idle. A configuration input selects between the wait-state handshake and a single-clock handshake. A second configuration input sets which level of the read/write line means "read".

Top module: `hostMemArbiter`

## Requirements
- R1: A synchronous reset, taken at any time including mid-transfer, drives `xferEnN` and `readyN` high and `hostDataOe` and `engGrant` low on the next rising edge.
- R2: `xferEnN` falls on the first rising edge at which `hostSelN` and `hostStrobeN` are both low and `engReq` is low. `engGrant` follows `engReq` one clock later while no host transfer is open, and stays low for the whole of a host transfer. `engGrant` and a low `xferEnN` are never seen together.
- R3: The address outputs follow `hostAddr` until the first rising edge after `xferEnN` falls, and keep that edge's value for the rest of the transfer.
- R4: `hostMemSel` and `hostRdWr` are followed until the first falling clock edge after `xferEnN` falls. Their values at that falling edge decide the target, the latency and the direction of the transfer.
- R5: When the frozen `hostMemSel` is 1, the transfer goes to the RAM on `ramAddr` = address bits 13..0. When it is 0, the transfer goes to the register file on `regAddr` = address bits 4..0. A write raises `ramWr` or `regWr` for exactly one clock, ending at the edge where `readyN` falls, with `wrData` = `hostDataIn`.
- R6: With `rdPolarity` = 1, a `hostRdWr` of 1 means read. With `rdPolarity` = 0, a `hostRdWr` of 0 means read.
- R7: With `waitStateEn` = 1, `readyN` falls on the 3rd rising edge after the edge that lowered `xferEnN` for a register access, and on the 7th for a RAM access.
- R8: With `waitStateEn` = 0, `readyN` falls on the 1st rising edge after the edge that lowered `xferEnN`, for either target.
- R9: On a read, `hostDataOut` is loaded with the addressed word at the edge where `readyN` falls, and `hostDataOe` rises at that same edge. Both, and `readyN`, hold steady until the strobe is seen high. `hostDataOe` stays low on writes.
- R10: A rising edge that sees `hostStrobeN` high during a transfer drives `xferEnN` and `readyN` high and `hostDataOe` low. If this happens before `readyN` has fallen, no write strobe is issued.
- R11: Raising `hostSelN` after `xferEnN` is low does not end or change the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostSelN | input | 1 | Host select, active low |
| hostStrobeN | input | 1 | Host strobe, active low; a high level ends the transfer |
| hostAddr | input | 16 | Host address |
| hostMemSel | input | 1 | 1 selects RAM, 0 selects register file |
| hostRdWr | input | 1 | Read/write line, sense set by `rdPolarity` |
| rdPolarity | input | 1 | 1: read when `hostRdWr` high; 0: read when low |
| waitStateEn | input | 1 | 1: target-dependent wait states; 0: single-clock handshake |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostDataOe | output | 1 | Enable for the host data bus drivers |
| xferEnN | output | 1 | Transfer enable, active low |
| readyN | output | 1 | Ready handshake, active low |
| engReq | input | 1 | Internal engine RAM request |
| engGrant | output | 1 | Internal engine RAM grant |
| ramAddr | output | 14 | RAM word address |
| ramWr | output | 1 | RAM write strobe |
| ramRdata | input | 16 | RAM read data |
| regAddr | output | 5 | Register index |
| regWr | output | 1 | Register write strobe |
| regRdata | input | 16 | Register read data |
| wrData | output | 16 | Write data to RAM or register file |

## Verification
The transfer function is driven with reads and writes to both targets. These cover both polarity settings and both handshake modes, with addresses whose unused upper bits are set. This separates the RAM and register latencies, checks each polarity against its opposite, and checks that the address is masked to the correct width. A directed transfer changes the address, the target select and the read/write line twice: once before the falling edge and once after the first rising edge. Only an implementation that freezes each signal at its own edge returns the expected word with the expected latency and no write. Further directed runs hold the engine request across a host request, raise it during a transfer, cut a write short with an early strobe, and reset a transfer mid-flight.

// File: rtl/hostArbPkg.sv
package hostArbPkg;

  // Control-to-datapath strobes, valid for the current clock cycle.
  typedef struct packed {
    logic active;     // a host transfer is open
    logic latchAddr;  // freeze the address at the coming rising edge
    logic loadRead;   // load read data at the coming rising edge
    logic writePulse; // write to the selected target at the coming edge
  } arbStrobes_t;

endpackage

// File: rtl/hostArbCtrl.sv
module hostArbCtrl
  import hostArbPkg::*;
#(
  parameter int REG_WAIT = 3,
  parameter int RAM_WAIT = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostSelN,
  input  logic        hostStrobeN,
  input  logic        waitStateEn,
  input  logic        engReq,
  input  logic        memSelEff,
  input  logic        isRead,
  output logic        xferEnN,
  output logic        readyN,
  output logic        dataOe,
  output logic        engGrant,
  output arbStrobes_t strobes
);

  localparam int MAX_WAIT = (RAM_WAIT > REG_WAIT) ? RAM_WAIT : REG_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_WAIT - 1);
  localparam logic [CNT_W-1:0] RAM_LAST = CNT_W'(RAM_WAIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} arbState_t;

  arbState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             hostReq;
  logic             atLast;

  always_comb begin
    hostReq = !hostSelN && !hostStrobeN;
    if (!waitStateEn) lastCnt = '0;
    else              lastCnt = memSelEff ? RAM_LAST : REG_LAST;
    atLast = (state == ST_WAIT) && (waitCnt == lastCnt);

    strobes.active     = (state != ST_IDLE);
    strobes.latchAddr  = (state == ST_WAIT) && (waitCnt == '0);
    strobes.loadRead   = atLast && !hostStrobeN && isRead;
    strobes.writePulse = atLast && !hostStrobeN && !isRead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      xferEnN  <= 1'b1;
      readyN   <= 1'b1;
      dataOe   <= 1'b0;
      engGrant <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          engGrant <= engReq;
          if (hostReq && !engReq) begin
            state    <= ST_WAIT;
            waitCnt  <= '0;
            xferEnN  <= 1'b0;
            engGrant <= 1'b0;
          end
        end
        ST_WAIT: begin
          engGrant <= 1'b0;
          if (hostStrobeN) begin
            state   <= ST_IDLE;
            xferEnN <= 1'b1;
            readyN  <= 1'b1;
            dataOe  <= 1'b0;
          end else if (atLast) begin
            state  <= ST_HOLD;
            readyN <= 1'b0;
            dataOe <= isRead;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: begin
          engGrant <= 1'b0;
          if (hostStrobeN) begin
            state   <= ST_IDLE;
            xferEnN <= 1'b1;
            readyN  <= 1'b1;
            dataOe  <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    engGrant |-> xferEnN); // R2
  AST_ENGINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (xferEnN && engReq) |=> xferEnN); // R2
  AST_READY_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    !readyN |-> !xferEnN); // R7
  AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> !readyN); // R9
  AST_STROBE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (!xferEnN && hostStrobeN) |=> (xferEnN && readyN && !dataOe)); // R10

endmodule

// File: rtl/hostArbDatapath.sv
module hostArbDatapath
  import hostArbPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int RAM_AW = 14,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  arbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostMemSel,
  input  logic              hostRdWr,
  input  logic              rdPolarity,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              memSelEff,
  output logic              isRead,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [REG_AW-1:0] regAddr,
  output logic              ramWr,
  output logic              regWr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] hostDataOut
);

  logic [ADDR_W-1:0] addrLat;
  logic              addrHeld;
  logic [ADDR_W-1:0] addrEff;
  logic              ctrlHeld;
  logic              memSelLat;
  logic              rdWrLat;
  logic              rdWrEff;
  logic              unusedAddrBits;

  // Address: transparent until the first rising edge of the transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      addrLat  <= '0;
      addrHeld <= 1'b0;
    end else if (strobes.latchAddr) begin
      addrLat  <= hostAddr;
      addrHeld <= 1'b1;
    end else if (!strobes.active) begin
      addrHeld <= 1'b0;
    end
  end

  // Target select and direction: frozen on the first falling edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      ctrlHeld  <= 1'b0;
      memSelLat <= 1'b0;
      rdWrLat   <= 1'b0;
    end else begin
      ctrlHeld <= strobes.active;
      if (strobes.active && !ctrlHeld) begin
        memSelLat <= hostMemSel;
        rdWrLat   <= hostRdWr;
      end
    end
  end

  always_comb begin
    addrEff   = addrHeld ? addrLat : hostAddr;
    memSelEff = (strobes.active && ctrlHeld) ? memSelLat : hostMemSel;
    rdWrEff   = (strobes.active && ctrlHeld) ? rdWrLat : hostRdWr;
    isRead    = rdPolarity ? rdWrEff : !rdWrEff;
    ramAddr   = addrEff[RAM_AW-1:0];
    regAddr   = addrEff[REG_AW-1:0];
    ramWr     = strobes.writePulse && memSelEff;
    regWr     = strobes.writePulse && !memSelEff;
    wrData    = hostDataIn;
  end

  assign unusedAddrBits = ^addrEff[ADDR_W-1:RAM_AW];

  always_ff @(posedge clk) begin
    if (rst)                   hostDataOut <= '0;
    else if (strobes.loadRead) hostDataOut <= memSelEff ? ramRdata : regRdata;
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (strobes.active && $past(strobes.active) && $past(strobes.active, 2))
      |-> $stable(ramAddr)); // R3

endmodule

// File: rtl/hostMemArbiter.sv
module hostMemArbiter #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int RAM_AW   = 14,
  parameter int REG_AW   = 5,
  parameter int REG_WAIT = 3,
  parameter int RAM_WAIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostSelN,
  input  logic              hostStrobeN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostMemSel,
  input  logic              hostRdWr,
  input  logic              rdPolarity,
  input  logic              waitStateEn,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              xferEnN,
  output logic              readyN,
  input  logic              engReq,
  output logic              engGrant,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWr,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWr,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] wrData
);

  hostArbPkg::arbStrobes_t strobes;
  logic memSelEff;
  logic isRead;

  hostArbCtrl #(
    .REG_WAIT(REG_WAIT),
    .RAM_WAIT(RAM_WAIT)
  ) ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostSelN   (hostSelN),
    .hostStrobeN(hostStrobeN),
    .waitStateEn(waitStateEn),
    .engReq     (engReq),
    .memSelEff  (memSelEff),
    .isRead     (isRead),
    .xferEnN    (xferEnN),
    .readyN     (readyN),
    .dataOe     (hostDataOe),
    .engGrant   (engGrant),
    .strobes    (strobes)
  );

  hostArbDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RAM_AW(RAM_AW),
    .REG_AW(REG_AW)
  ) dpath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .hostAddr   (hostAddr),
    .hostMemSel (hostMemSel),
    .hostRdWr   (hostRdWr),
    .rdPolarity (rdPolarity),
    .hostDataIn (hostDataIn),
    .ramRdata   (ramRdata),
    .regRdata   (regRdata),
    .memSelEff  (memSelEff),
    .isRead     (isRead),
    .ramAddr    (ramAddr),
    .regAddr    (regAddr),
    .ramWr      (ramWr),
    .regWr      (regWr),
    .wrData     (wrData),
    .hostDataOut(hostDataOut)
  );

endmodule

// File: tb/hostMemArbiter_test.sv
module hostMemArbiter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostSelN = 1'b1, hostStrobeN = 1'b1;
  logic [15:0] hostAddr = '0;
  logic        hostMemSel = 1'b0, hostRdWr = 1'b1, rdPolarity = 1'b1, waitStateEn = 1'b1;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe, xferEnN, readyN, engGrant;
  logic        engReq = 1'b0;
  logic [13:0] ramAddr;
  logic        ramWr, regWr;
  logic [15:0] ramRdata, regRdata, wrData;
  logic [4:0]  regAddr;

  always #5 clk = ~clk;

  hostMemArbiter uut (.*);

  // Target models: read data is a fixed function of the address.
  assign ramRdata = {ramAddr, 2'b10};
  assign regRdata = {11'h528, regAddr};

  function automatic logic [15:0] expRead(input logic mem, input logic [15:0] a);
    return mem ? {a[13:0], 2'b10} : {11'h528, a[4:0]};
  endfunction

  int          checks = 0, fails = 0;
  bit          finished = 1'b0;
  int          wrCnt = 0;
  logic        lastWrRam;
  logic [13:0] lastWrAddr;
  logic [15:0] lastWrData;

  always @(posedge clk) begin
    if (ramWr || regWr) begin
      wrCnt++;
      lastWrRam  = ramWr;
      lastWrAddr = ramWr ? ramAddr : {9'd0, regAddr};
      lastWrData = wrData;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  typedef struct packed {
    logic        memSel;
    logic        rdWr;
    logic        pol;
    logic        waitEn;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [3:0]  expLat;
    logic        expIsRead;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hC123, 16'h0000, 4'd7, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'hFFE3, 16'h0000, 4'd3, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h2ABC, 16'hBEEF, 4'd7, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'h001F, 16'h1234, 4'd3, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'h3FFF, 16'h0000, 4'd7, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'h4000, 16'hA5A5, 4'd7, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0007, 16'h0000, 4'd1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0F0F, 4'd1, 1'b0}
  };

  // Wait edges until readyN falls; returns number of edges counted.
  task automatic waitReady(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (readyN && n < 12);
  endtask

  task automatic endXfer(input string tag);
    #1 hostStrobeN = 1'b1; hostSelN = 1'b1;
    @(posedge clk); #1;
    check(xferEnN && readyN && !hostDataOe, tag, {xferEnN, readyN, hostDataOe}, 3'b110);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(xferEnN && readyN && !hostDataOe && !engGrant, "R1 reset idle",
          {xferEnN, readyN, hostDataOe, engGrant}, 4'b1100);
    #1 rst = 1'b0;

    // Vector table walk: R2 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VECS[i];
      int n;
      int wrBefore = wrCnt;
      hostMemSel = v.memSel; hostRdWr = v.rdWr; rdPolarity = v.pol;
      waitStateEn = v.waitEn; hostAddr = v.addr; hostDataIn = v.wdata;
      hostSelN = 1'b0; hostStrobeN = 1'b0;
      @(posedge clk); #1;
      check(!xferEnN, "R2 start edge", {31'd0, xferEnN}, 0);
      waitReady(n);
      check(n == int'(v.expLat), v.waitEn ? "R7 wait latency" : "R8 single-clock latency", n, v.expLat);
      if (v.expIsRead) begin
        check(hostDataOe, "R9/R6 read enables bus", {31'd0, hostDataOe}, 1);
        check(hostDataOut == expRead(v.memSel, v.addr), "R5/R9 read data", hostDataOut,
              expRead(v.memSel, v.addr));
        check(wrCnt == wrBefore, "R6 no write on read", wrCnt, wrBefore);
      end else begin
        check(!hostDataOe, "R9 no drive on write", {31'd0, hostDataOe}, 0);
        check(wrCnt == wrBefore + 1, "R5/R6 one write strobe", wrCnt, wrBefore + 1);
        check(lastWrRam == v.memSel, "R5 write target", {31'd0, lastWrRam}, v.memSel);
        check(lastWrAddr == (v.memSel ? v.addr[13:0] : {9'd0, v.addr[4:0]}), "R5 write address",
              lastWrAddr, v.memSel ? v.addr[13:0] : {9'd0, v.addr[4:0]});
        check(lastWrData == v.wdata, "R5 write data", lastWrData, v.wdata);
      end
      endXfer("R10 strobe ends");
    end

    // Directed: latch edges R3 R4, select release R11, hold R9
    begin
      int n;
      int wrBefore = wrCnt;
      logic [15:0] holdData;
      rdPolarity = 1'b1; waitStateEn = 1'b1;
      hostMemSel = 1'b0; hostRdWr = 1'b0; hostAddr = 16'h0111;
      hostSelN = 1'b0; hostStrobeN = 1'b0;
      @(posedge clk); #1;
      check(!xferEnN, "R2 start", {31'd0, xferEnN}, 0);
      #1 hostMemSel = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h0222; hostSelN = 1'b1;
      @(posedge clk); #1;
      #1 hostMemSel = 1'b0; hostRdWr = 1'b0; hostAddr = 16'h0333;
      waitReady(n);
      n = n + 1;
      check(n == 7, "R4 RAM latency from falling-edge select", n, 7);
      check(ramAddr == 14'h0222, "R3 address frozen", ramAddr, 14'h0222);
      check(hostDataOe && hostDataOut == expRead(1'b1, 16'h0222), "R4/R3 read of frozen word",
            hostDataOut, expRead(1'b1, 16'h0222));
      check(wrCnt == wrBefore, "R4 direction frozen as read", wrCnt, wrBefore);
      holdData = hostDataOut;
      repeat (3) @(posedge clk);
      #1;
      check(!readyN && hostDataOe && hostDataOut == holdData && !xferEnN, "R9/R11 held until strobe",
            hostDataOut, holdData);
      endXfer("R10 strobe ends");
    end

    // Directed: engine priority and grant blocking R2, abort R10
    begin
      int wrBefore = wrCnt;
      engReq = 1'b1;
      @(posedge clk); #1;
      check(engGrant, "R2 grant follows request", {31'd0, engGrant}, 1);
      #1 hostMemSel = 1'b1; hostRdWr = 1'b0; hostAddr = 16'h0044; hostDataIn = 16'h7777;
      hostSelN = 1'b0; hostStrobeN = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(xferEnN && engGrant, "R2 host waits for engine", {xferEnN, engGrant}, 2'b11);
      #1 engReq = 1'b0;
      @(posedge clk); #1;
      check(!xferEnN && !engGrant, "R2 host starts after engine", {xferEnN, engGrant}, 2'b00);
      #1 engReq = 1'b1;
      @(posedge clk); #1;
      check(!engGrant, "R2 grant blocked during host transfer", {31'd0, engGrant}, 0);
      endXfer("R10 early strobe ends");
      check(wrCnt == wrBefore, "R10 no write on early end", wrCnt, wrBefore);
      @(posedge clk); #1;
      check(engGrant, "R2 grant after host transfer", {31'd0, engGrant}, 1);
      #1 engReq = 1'b0;
      @(posedge clk); #1;
    end

    // Directed: reset mid-transfer R1
    begin
      int n;
      hostMemSel = 1'b0; hostRdWr = 1'b1; rdPolarity = 1'b1; hostAddr = 16'h0005;
      hostSelN = 1'b0; hostStrobeN = 1'b0;
      @(posedge clk); #1;
      waitReady(n);
      #1 rst = 1'b1; hostSelN = 1'b1; hostStrobeN = 1'b1;
      @(posedge clk); #1;
      check(xferEnN && readyN && !hostDataOe && !engGrant, "R1 reset mid-transfer",
            {xferEnN, readyN, hostDataOe, engGrant}, 4'b1100);
      #1 rst = 1'b0;
      @(posedge clk); #1;
    end

    finishRun();
  end

endmodule